// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block is the device-side status logic of a NOR-style flash part. It follows the write strobes of command sequences to tell when an internal program or erase algorithm has been launched. While an algorithm runs, it answers reads with a status byte in place of array data, and it drives a ready/busy indication. Three status bits carry the information: a data-polling bit (bit 7), a toggle bit that inverts on every read while an algorithm is active (bit 6), and a sector toggle bit (bit 2) that inverts only when the read falls in the sector under erase or in erase suspend.

The flash array, the full command set and the internal algorithm timing are outside the block. Array data comes in on a port. Suspend, resume and completion arrive as single-cycle strobes. The ready/busy output is an active-low pull-down enable plus a drive value. Several instances can therefore share one wired-AND line with a pull-up.

Top module: `flash_status_gen`

## Requirements
- R1: While `rst_ni` is low, `rb_oe_no` is 0 (busy). After reset the block is idle, `rb_oe_no` is 1, and a read returns `arr_data_i` unchanged.
- R2: A program starts on the clock edge that samples the 4th `we_i` pulse with `seq_erase_i`=0. `rb_oe_no` is 0 from that edge on, and stays 1 after only 3 pulses. The address and data of the 4th pulse are the program target.
- R3: An erase starts on the clock edge that samples the 6th `we_i` pulse with `seq_erase_i`=1. Its sector comes from `wr_sector_i` of that pulse, and `rb_oe_no` is 0 from that edge on. After 4 such pulses no operation has started.
- R4: In program, erase and suspend-program, bit 6 of `rd_data_o` inverts after every sampled read (`re_i`=1), whatever the address or sector.
- R5: During erase, bit 2 inverts after a read only when `rd_sector_i` equals the erasing sector. Reads from other sectors leave it unchanged. Bit 7 reads 0.
- R6: During a program, the status byte is bit 7 = complement of bit 7 of the program data, bit 6 = toggle, bit 2 = 1. All other bits are 0 in every status byte.
- R7: A `suspend_i` strobe during erase enters suspend-read, and `rb_oe_no` becomes 1. Reads from the suspended sector return bit 7 = 1, bit 6 = 1 and a toggling bit 2. Reads from other sectors return array data. `resume_i` returns to erase and busy.
- R8: In suspend-read, 4 program write pulses start a suspend-program with `rb_oe_no`=0. A read at the program address returns bit 2 = 1. Reads from the suspended sector return a toggling bit 2. `done_i` returns to suspend-read.
- R9: A `done_i` strobe during program or erase returns to idle. `rb_oe_no` becomes 1 and reads return array data.
- R10: At every operation start the bit-6 toggle clears to 0. A start from idle also clears the bit-2 toggle, so the first status read shows 0 in the toggle bits.
- R11: `rb_drv_o` is always 0. The line value is `rb_oe_no ? 1 : rb_drv_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | One-cycle write strobe (write pulse rising edge) |
| seq_erase_i | input | 1 | 1 when the current write belongs to an erase sequence |
| wr_addr_i | input | AW | Write address |
| wr_sector_i | input | SW | Sector of the write |
| wr_data_i | input | 8 | Write data |
| re_i | input | 1 | One-cycle read strobe |
| rd_addr_i | input | AW | Read address |
| rd_sector_i | input | SW | Sector of the read |
| arr_data_i | input | 8 | Array data for reads when no status is due |
| suspend_i | input | 1 | Erase suspend strobe |
| resume_i | input | 1 | Erase resume strobe |
| done_i | input | 1 | Algorithm completion strobe |
| rd_data_o | output | 8 | Read data or status byte |
| rb_oe_no | output | 1 | Active-low pull-down enable of ready/busy |
| rb_drv_o | output | 1 | Value driven when enabled |

## Verification
A wrong mode state would show as a busy level that disagrees with the write count or with a strobe, one clock after the edge involved. A toggle flop that fails to flip or to clear shows a wrong bit 6 or bit 2 on the very next read. A corrupt erase-sector mask shows as bit 2 moving on a read from the wrong sector, or as array data where status was due. The bench therefore checks every read in sequence and sets reads from hit and miss sectors side by side.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_SUS_RD,
    ST_SUS_PRG
  } fsg_state_e;

  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TGL_BIT  = 6;
  localparam int unsigned SEC_BIT  = 2;
endpackage

// File: rtl/fsg_cmd_track.sv
module fsg_cmd_track
  import fsg_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned PROG_CYC  = 4,
  parameter int unsigned ERASE_CYC = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          seq_erase_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          suspend_i,
  input  logic          resume_i,
  input  logic          done_i,
  output fsg_state_e    st_o,
  output logic          start_o,
  output logic          fresh_o,
  output logic          erase_set_o,
  output logic          erase_end_o,
  output logic [AW-1:0] prog_addr_o,
  output logic [7:0]    prog_data_o
);
  localparam int unsigned CW = $clog2(ERASE_CYC + 1);
  localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYC - 1);

  fsg_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] pa_q;
  logic [7:0]    pd_q;
  logic          can_cnt, start_prog, start_erase, mode_evt;

  assign can_cnt     = (st_q == ST_IDLE) || (st_q == ST_SUS_RD);
  assign start_prog  = can_cnt && we_i && !seq_erase_i && (cnt_q == PROG_LAST);
  assign start_erase = (st_q == ST_IDLE) && we_i && seq_erase_i && (cnt_q == ERASE_LAST);
  assign mode_evt    = suspend_i || resume_i || done_i;

  always_comb begin
    cnt_d = cnt_q;
    if (!can_cnt || start_prog || start_erase || mode_evt) cnt_d = '0;
    else if (we_i) cnt_d = (cnt_q == ERASE_LAST) ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start_prog) st_d = ST_PROG;
                  else if (start_erase) st_d = ST_ERASE;
      ST_PROG:    if (done_i) st_d = ST_IDLE;
      ST_ERASE:   if (done_i) st_d = ST_IDLE;
                  else if (suspend_i) st_d = ST_SUS_RD;
      ST_SUS_RD:  if (resume_i) st_d = ST_ERASE;
                  else if (start_prog) st_d = ST_SUS_PRG;
      ST_SUS_PRG: if (done_i) st_d = ST_SUS_RD;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      pa_q  <= '0;
      pd_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (start_prog) begin
        pa_q <= wr_addr_i;
        pd_q <= wr_data_i;
      end
    end
  end

  assign st_o        = st_q;
  assign start_o     = start_prog || start_erase;
  assign fresh_o     = (st_q == ST_IDLE) && (start_prog || start_erase);
  assign erase_set_o = start_erase;
  assign erase_end_o = (st_q == ST_ERASE) && done_i;
  assign prog_addr_o = pa_q;
  assign prog_data_o = pd_q;

  assert_prog_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && we_i && !seq_erase_i && cnt_q == PROG_LAST) |=> (st_q == ST_PROG));

  assert_erase_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && we_i && seq_erase_i && cnt_q == ERASE_LAST) |=> (st_q == ST_ERASE));

  assert_suspend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ERASE && suspend_i && !done_i) |=> (st_q == ST_SUS_RD));
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic t6_flip_i,
  input  logic t6_clr_i,
  input  logic t2_flip_i,
  input  logic t2_clr_i,
  output logic t6_o,
  output logic t2_o
);
  logic t6_q, t2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else begin
      if (t6_clr_i) t6_q <= 1'b0;
      else if (t6_flip_i) t6_q <= ~t6_q;
      if (t2_clr_i) t2_q <= 1'b0;
      else if (t2_flip_i) t2_q <= ~t2_q;
    end
  end

  assign t6_o = t6_q;
  assign t2_o = t2_q;

  assert_t6_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t6_clr_i |=> !t6_q);

  assert_t6_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t6_flip_i && !t6_clr_i) |=> (t6_q != $past(t6_q)));

  assert_t2_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!t2_flip_i && !t2_clr_i) |=> $stable(t2_q));
endmodule

// File: rtl/fsg_sector_mask.sv
module fsg_sector_mask #(
  parameter int unsigned NSEC = 16,
  localparam int unsigned SW  = $clog2(NSEC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [SW-1:0] set_sector_i,
  input  logic          clr_i,
  input  logic [SW-1:0] rd_sector_i,
  output logic          hit_o
);
  logic [NSEC-1:0] mask_q, hit_vec;

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[g] <= 1'b0;
      else if (set_i) mask_q[g] <= (set_sector_i == SW'(g));
      else if (clr_i) mask_q[g] <= 1'b0;
    end
    assign hit_vec[g] = mask_q[g] && (rd_sector_i == SW'(g));
  end

  assign hit_o = |hit_vec;

  assert_one_sector_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ($countones(mask_q) == 1));

  assert_mask_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> $onehot0(mask_q) && (mask_q == '0));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned NSEC      = 16,
  parameter int unsigned PROG_CYC  = 4,
  parameter int unsigned ERASE_CYC = 6,
  localparam int unsigned SW       = $clog2(NSEC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          seq_erase_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [SW-1:0] wr_sector_i,
  input  logic [7:0]    wr_data_i,
  input  logic          re_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [SW-1:0] rd_sector_i,
  input  logic [7:0]    arr_data_i,
  input  logic          suspend_i,
  input  logic          resume_i,
  input  logic          done_i,
  output logic [7:0]    rd_data_o,
  output logic          rb_oe_no,
  output logic          rb_drv_o
);
  fsg_state_e    st;
  logic          start, fresh, er_set, er_end;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic          sec_hit, prog_hit, t6, t2, t6_flip, t2_flip, busy;
  logic [7:0]    stat;

  fsg_cmd_track #(
    .AW(AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_cmd (
    .clk_i, .rst_ni, .we_i, .seq_erase_i, .wr_addr_i, .wr_data_i,
    .suspend_i, .resume_i, .done_i,
    .st_o(st), .start_o(start), .fresh_o(fresh),
    .erase_set_o(er_set), .erase_end_o(er_end),
    .prog_addr_o(prog_addr), .prog_data_o(prog_data)
  );

  fsg_sector_mask #(.NSEC(NSEC)) u_mask (
    .clk_i, .rst_ni,
    .set_i(er_set), .set_sector_i(wr_sector_i), .clr_i(er_end),
    .rd_sector_i, .hit_o(sec_hit)
  );

  assign busy     = (st == ST_PROG) || (st == ST_ERASE) || (st == ST_SUS_PRG);
  assign prog_hit = (rd_addr_i == prog_addr);
  assign t6_flip  = re_i && busy;
  assign t2_flip  = re_i && sec_hit &&
                    ((st == ST_ERASE) || (st == ST_SUS_RD) || (st == ST_SUS_PRG && !prog_hit));

  fsg_toggle u_tgl (
    .clk_i, .rst_ni,
    .t6_flip_i(t6_flip), .t6_clr_i(start),
    .t2_flip_i(t2_flip), .t2_clr_i(fresh),
    .t6_o(t6), .t2_o(t2)
  );

  always_comb begin
    stat = 8'h00;
    unique case (st)
      ST_PROG: begin
        stat[POLL_BIT] = ~prog_data[7];
        stat[TGL_BIT]  = t6;
        stat[SEC_BIT]  = 1'b1;
      end
      ST_ERASE: begin
        stat[TGL_BIT]  = t6;
        stat[SEC_BIT]  = t2;
      end
      ST_SUS_RD: begin
        stat[POLL_BIT] = 1'b1;
        stat[TGL_BIT]  = 1'b1;
        stat[SEC_BIT]  = t2;
      end
      ST_SUS_PRG: begin
        stat[POLL_BIT] = ~prog_data[7];
        stat[TGL_BIT]  = t6;
        stat[SEC_BIT]  = (sec_hit && !prog_hit) ? t2 : 1'b1;
      end
      default: stat = 8'h00;
    endcase
  end

  always_comb begin
    if (st == ST_IDLE || (st == ST_SUS_RD && !sec_hit)) rd_data_o = arr_data_i;
    else rd_data_o = stat;
  end

  // pull-down active during reset and while an algorithm runs
  assign rb_oe_no = rst_ni && !busy;
  assign rb_drv_o = 1'b0;

  assert_sus_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ERASE && suspend_i && !done_i) |=> rb_oe_no);

  assert_done_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_PROG || st == ST_ERASE) && done_i) |=> (rb_oe_no && rd_data_o == arr_data_i));

  assert_sus_prog_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SUS_RD && start) |=> !rb_oe_no);
endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
  localparam int AW = 16;
  localparam int NSEC = 16;
  localparam int SW = $clog2(NSEC);
  localparam int M_IDLE = 0, M_PROG = 1, M_ERASE = 2, M_SRD = 3, M_SPRG = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          rst_n = 1'b0;
  logic          we = 0, seq_er = 0, re = 0, sus = 0, res = 0, dn = 0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [SW-1:0] ws = '0, rs = '0;
  logic [7:0]    wd = '0, arr;
  logic [7:0]    rdata;
  logic          rb_oe_n, rb_drv;

  assign arr = {ra[3:0], 4'h9};

  flash_status_gen #(.AW(AW), .NSEC(NSEC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .seq_erase_i(seq_er),
    .wr_addr_i(wa), .wr_sector_i(ws), .wr_data_i(wd),
    .re_i(re), .rd_addr_i(ra), .rd_sector_i(rs), .arr_data_i(arr),
    .suspend_i(sus), .resume_i(res), .done_i(dn),
    .rd_data_o(rdata), .rb_oe_no(rb_oe_n), .rb_drv_o(rb_drv)
  );

  typedef struct {
    logic [7:0] d;
    logic       rb;
    bit         cmp_d;
    string      tag;
  } item_t;

  item_t q[$];
  bit    sample_req = 0;
  int    n_vec = 0, n_bad = 0;

  // model state from the requirements
  int         m_st = M_IDLE;
  logic       m_t6 = 0, m_t2 = 0;
  logic [7:0] m_pd = 0;
  logic [AW-1:0] m_pa = 0;
  logic [SW-1:0] m_es = 0;

  // monitor
  always @(negedge clk) begin
    if (sample_req && q.size() > 0) begin
      item_t it;
      logic line;
      it = q.pop_front();
      n_vec++;
      line = rb_oe_n ? 1'b1 : rb_drv;
      if (line !== it.rb) begin
        n_bad++;
        $display("FAIL %s: ready line %b expected %b", it.tag, line, it.rb);
      end else if (it.cmp_d && rdata !== it.d) begin
        n_bad++;
        $display("FAIL %s: rd_data %02h expected %02h", it.tag, rdata, it.d);
      end
    end
  end

  function automatic logic m_busy();
    return (m_st == M_PROG) || (m_st == M_ERASE) || (m_st == M_SPRG);
  endfunction

  task automatic push(input logic [7:0] d, input logic rb, input bit cd, input string tag);
    item_t it;
    it.d = d; it.rb = rb; it.cmp_d = cd; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk_rb(input string tag);
    @(posedge clk); #1;
    push(8'h00, rst_n && !m_busy(), 0, tag);
    sample_req = 1;
    @(posedge clk); #1;
    sample_req = 0;
  endtask

  // expected read result, then model toggle update
  task automatic rd(input logic [AW-1:0] a, input logic [SW-1:0] s, input string tag);
    logic [7:0] e;
    logic hit;
    hit = (s == m_es);
    e = {a[3:0], 4'h9};
    case (m_st)
      M_PROG:  begin e = {~m_pd[7], m_t6, 3'b000, 1'b1, 2'b00}; m_t6 = ~m_t6; end
      M_ERASE: begin e = {1'b0, m_t6, 3'b000, m_t2, 2'b00}; m_t6 = ~m_t6; if (hit) m_t2 = ~m_t2; end
      M_SRD:   if (hit) begin e = {2'b11, 3'b000, m_t2, 2'b00}; m_t2 = ~m_t2; end
      M_SPRG: begin
        if (a != m_pa && hit) begin e = {~m_pd[7], m_t6, 3'b000, m_t2, 2'b00}; m_t2 = ~m_t2; end
        else e = {~m_pd[7], m_t6, 3'b000, 1'b1, 2'b00};
        m_t6 = ~m_t6;
      end
      default: ;
    endcase
    @(posedge clk); #1;
    re = 1; ra = a; rs = s;
    push(e, !m_busy(), 1, tag);
    sample_req = 1;
    @(posedge clk); #1;
    re = 0; sample_req = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [SW-1:0] s, input logic [7:0] d, input logic er);
    @(posedge clk); #1;
    we = 1; wa = a; ws = s; wd = d; seq_er = er;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic strobe(input int which);
    @(posedge clk); #1;
    if (which == 0) sus = 1; else if (which == 1) res = 1; else dn = 1;
    @(posedge clk); #1;
    sus = 0; res = 0; dn = 0;
  endtask

  task automatic prog_seq(input logic [AW-1:0] a, input logic [7:0] d);
    for (int i = 0; i < 3; i++) wr(16'h0555 + AW'(i), 4'd0, 8'hAA, 0);
    wr(a, 4'd0, d, 0);
    if (m_st == M_IDLE) begin m_t2 = 0; m_st = M_PROG; end else m_st = M_SPRG;
    m_t6 = 0; m_pa = a; m_pd = d;
  endtask

  bit fin = 0;

  initial begin
    // R1: busy during reset
    chk_rb("R1 reset busy");
    #3 rst_n = 1;
    chk_rb("R1 ready after reset");
    rd(16'h0005, 4'd2, "R1 idle read array");

    // R2: three writes do not start, fourth does
    for (int i = 0; i < 3; i++) wr(16'h0555, 4'd0, 8'hAA, 0);
    chk_rb("R2 not busy after 3 writes");
    wr(16'h0010, 4'd0, 8'h3C, 0);
    m_st = M_PROG; m_t6 = 0; m_t2 = 0; m_pa = 16'h0010; m_pd = 8'h3C;
    chk_rb("R2 busy after 4th write");
    rd(16'h0010, 4'd0, "R10 first program read toggles 0");
    rd(16'h0123, 4'd5, "R4 R6 program status other addr");
    rd(16'h0FFF, 4'd9, "R4 program toggle again");
    strobe(2); m_st = M_IDLE;
    chk_rb("R9 ready after program done");
    rd(16'h0007, 4'd0, "R9 array data after done");

    // R3: erase sequence
    for (int i = 0; i < 4; i++) wr(16'h0555, 4'd0, 8'h55, 1);
    chk_rb("R3 not busy after 4 erase writes");
    wr(16'h0555, 4'd0, 8'h55, 1);
    wr(16'h3000, 4'd3, 8'h30, 1);
    m_st = M_ERASE; m_t6 = 0; m_t2 = 0; m_es = 4'd3;
    chk_rb("R3 busy after 6th write");
    rd(16'h3001, 4'd3, "R10 R5 erase first read");
    rd(16'h3002, 4'd3, "R5 erase sector toggle");
    rd(16'h7000, 4'd7, "R5 other sector holds bit 2");
    rd(16'h3003, 4'd3, "R5 erase sector again");
    rd(16'h7001, 4'd7, "R4 R5 other sector read");

    // R7: suspend-read
    strobe(0); m_st = M_SRD;
    chk_rb("R7 ready in suspend");
    rd(16'h3004, 4'd3, "R7 suspended sector status");
    rd(16'h3005, 4'd3, "R7 suspended sector toggles");
    rd(16'h0008, 4'd7, "R7 other sector array data");

    // R8: suspend-program
    prog_seq(16'h0200, 8'h81);
    chk_rb("R8 busy in suspend program");
    rd(16'h0200, 4'd1, "R8 program address bit 2 one");
    rd(16'h3006, 4'd3, "R8 suspended sector toggles");
    rd(16'h3007, 4'd3, "R8 suspended sector toggles again");
    rd(16'h0200, 4'd1, "R8 R4 program address again");
    strobe(2); m_st = M_SRD;
    chk_rb("R8 back to suspend read");
    rd(16'h3008, 4'd3, "R7 suspend read after program");

    // resume then complete
    strobe(1); m_st = M_ERASE;
    chk_rb("R7 busy after resume");
    rd(16'h3009, 4'd3, "R5 erase after resume");
    strobe(2); m_st = M_IDLE;
    chk_rb("R9 ready after erase done");
    rd(16'h300A, 4'd3, "R9 array data after erase");

    // R11 / R1: reset during busy
    prog_seq(16'h0044, 8'h00);
    rd(16'h0044, 4'd0, "R6 program bit 7 of zero data");
    @(posedge clk); #1 rst_n = 0;
    m_st = M_IDLE;
    chk_rb("R11 R1 reset forces line low");
    #3 rst_n = 1;
    chk_rb("R1 ready after second reset");
    rd(16'h000B, 4'd0, "R1 idle after reset");

    repeat (4) @(posedge clk);
    fin = 1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (fin) break;
    end
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule